// File: doc/BRIEF.md
# Key-Selected Configuration Data Port

This peripheral gives a processor byte-by-byte access to a small set of configuration items. Software first writes a 16-bit key to a selector register. The block then serves the chosen item through one byte-wide data register. Each read returns the next byte, and each write stores the next byte, because an internal offset advances on its own. Items live in two banks of byte buffers, and every buffer has its own programmed length. The host side fills buffers and sets lengths through a separate preload port.

Software can fill an item by writing to it when its key carries the write flag. Once the last byte of such an item has been stored, the block emits a one-cycle completion pulse tagged with the bank and index of that item, and the offset rewinds to the start. After reset the block behaves as if key 0 had just been selected. Bank 0 item 0 then holds a 4-byte signature and bank 0 item 1 holds the identifier 1, each stored least-significant byte first.

Requests arrive as a valid-qualified bus beat. The block never stalls and takes one beat per cycle, so it applies no back-pressure. Every read beat gets a registered response on `rd_valid`/`rd_data` in the next cycle.

Top module: `cfgp_port`

## Requirements
- R1: After reset the current key is 0 with offset 0. Bank 0 item 0 holds the bytes of `SIG_WORD`, least significant first, with length 4. Bank 0 item 1 holds `ID_WORD` (default 1), LSB first, with length 4. All other items have length 0. `rd_valid` and `done` are low.
- R2: A write beat to address `SEL_ADDR` selects a new key and always clears the offset to 0, even when the same key is written again. Key bit 15 picks the bank, key bit 14 is the write flag, and bits 13:0 form the item index.
- R3: A selected index of `NUM_ITEMS` or more makes the key invalid, and it is stored as 0xFFFF. Reads of data then return 0x00, and data writes are dropped with no completion pulse and no stored byte.
- R4: A read beat to `DATA_ADDR` is answered one cycle later with `rd_valid` high. `rd_data` carries the byte at the current offset of the current item, and the offset then advances by one.
- R5: A data read with an invalid key, an item of length 0, or an offset equal to the length returns 0x00 and leaves the offset unchanged.
- R6: A data write (byte in `bus_wdata[7:0]`) is accepted only when the key is valid, has bit 14 set and the offset is below the item length. The byte is stored at the offset, and the offset advances. Any other data write changes nothing.
- R7: An accepted write that stores the last byte of the item raises `done` for exactly the following cycle, with `done_bank`/`done_idx` naming that item, and resets the offset to 0.
- R8: Read beats to any address other than `DATA_ADDR` return 0x00 and do not move the offset. Write beats to addresses that are neither `SEL_ADDR` nor `DATA_ADDR` have no effect.
- R9: A preload length write sets the item length, and values above `MAX_LEN` are clamped to `MAX_LEN`. A preload byte write stores `pre_byte` at the given bank, index and offset.
- R10: The two banks are separate. The same index in bank 0 and bank 1 names different buffers and lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus beat present this cycle |
| bus_write | input | 1 | 1 = write beat, 0 = read beat |
| bus_addr | input | ADDR_W | Register address of the beat |
| bus_wdata | input | 16 | Write data (key, or byte in bits 7:0) |
| rd_valid | output | 1 | Read response strobe, one cycle after a read beat |
| rd_data | output | 8 | Read response byte |
| pre_we | input | 1 | Preload one byte |
| pre_len_we | input | 1 | Preload one item length |
| pre_bank | input | 1 | Preload bank |
| pre_idx | input | IDX_W | Preload item index |
| pre_off | input | OFF_W | Preload byte offset |
| pre_byte | input | 8 | Preload byte value |
| pre_len | input | 8 | Preload length value |
| done | output | 1 | One-cycle completion pulse for a filled item |
| done_bank | output | 1 | Bank of the filled item |
| done_idx | output | IDX_W | Index of the filled item |

## Verification
The bench builds the block with `NUM_ITEMS` = 12, `MAX_LEN` = 8 and `DATA_ADDR` = 2, which places the data register at the memory-mapped position. With 12 items, keys whose 4-bit index is 12 to 15 fall into the invalid range and are easy for random stimulus to hit. A length of 8 lets short runs fill items completely, read past their ends and hit length clamping. With this setting the wrap-around after completion, the rewind on re-select and the bank split all come up many times per run.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  typedef struct packed {
    logic        bank;
    logic        wr_flag;
    logic [13:0] idx;
  } cfgp_key_t;

  localparam logic [15:0] CFGP_KEY_BAD = 16'hFFFF;
endpackage

// File: rtl/cfgp_key_dec.sv
`timescale 1ns/1ps
module cfgp_key_dec
  import cfgp_pkg::*;
#(
  parameter int NUM_ITEMS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_we,
  input  logic [15:0] sel_key,
  output cfgp_key_t   cur_key,
  output logic        key_ok
);
  logic in_range;
  assign in_range = int'(sel_key[13:0]) < NUM_ITEMS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_key <= '0;
      key_ok  <= 1'b1;
    end else if (sel_we) begin
      cur_key <= in_range ? cfgp_key_t'(sel_key) : cfgp_key_t'(CFGP_KEY_BAD);
      key_ok  <= in_range;
    end
  end
endmodule

// File: rtl/cfgp_store.sv
`timescale 1ns/1ps
module cfgp_store #(
  parameter int          NUM_ITEMS = 16,
  parameter int          MAX_LEN   = 16,
  parameter logic [31:0] SIG_WORD  = 32'h50474643,
  parameter logic [31:0] ID_WORD   = 32'h00000001,
  localparam int IDX_W = $clog2(NUM_ITEMS),
  localparam int OFF_W = $clog2(MAX_LEN),
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_we,
  input  logic             pre_len_we,
  input  logic             pre_bank,
  input  logic [IDX_W-1:0] pre_idx,
  input  logic [OFF_W-1:0] pre_off,
  input  logic [7:0]       pre_byte,
  input  logic [7:0]       pre_len,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             cur_bank,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [OFF_W-1:0] cur_off,
  output logic [7:0]       cur_byte,
  output logic [LEN_W-1:0] cur_len
);
  logic [7:0]       mem_q [2][NUM_ITEMS][MAX_LEN];
  logic [LEN_W-1:0] len_q [2][NUM_ITEMS];
  logic             pre_hit;
  logic [LEN_W-1:0] pre_len_cl;

  function automatic logic [7:0] init_byte(int b, int i, int o);
    if (b == 0 && i == 0 && o < 4) return SIG_WORD[8*o +: 8];
    if (b == 0 && i == 1 && o < 4) return ID_WORD[8*o +: 8];
    return 8'h00;
  endfunction

  function automatic logic [LEN_W-1:0] init_len(int b, int i);
    return (b == 0 && i < 2) ? LEN_W'(4) : '0;
  endfunction

  assign pre_hit    = int'(pre_idx) < NUM_ITEMS;
  assign pre_len_cl = (int'(pre_len) > MAX_LEN) ? LEN_W'(MAX_LEN) : LEN_W'(pre_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < NUM_ITEMS; i++) begin
          len_q[b][i] <= init_len(b, i);
          for (int o = 0; o < MAX_LEN; o++) mem_q[b][i][o] <= init_byte(b, i, o);
        end
      end
    end else begin
      if (pre_we && pre_hit) mem_q[pre_bank][pre_idx][pre_off] <= pre_byte;
      else if (wr_en) mem_q[cur_bank][cur_idx][cur_off] <= wr_byte;
      if (pre_len_we && pre_hit) len_q[pre_bank][pre_idx] <= pre_len_cl;
    end
  end

  assign cur_byte = mem_q[cur_bank][cur_idx][cur_off];
  assign cur_len  = len_q[cur_bank][cur_idx];
endmodule

// File: rtl/cfgp_cursor.sv
`timescale 1ns/1ps
module cfgp_cursor #(
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rewind,
  input  logic             step,
  output logic [LEN_W-1:0] off
);
  always_ff @(posedge clk) begin
    if (!rst_n)      off <= '0;
    else if (rewind) off <= '0;
    else if (step)   off <= off + LEN_W'(1);
  end
endmodule

// File: rtl/cfgp_port.sv
`timescale 1ns/1ps
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int          NUM_ITEMS = 16,
  parameter int          MAX_LEN   = 16,
  parameter int          ADDR_W    = 2,
  parameter int          SEL_ADDR  = 0,
  parameter int          DATA_ADDR = 1,
  parameter logic [31:0] SIG_WORD  = 32'h50474643,
  parameter logic [31:0] ID_WORD   = 32'h00000001,
  localparam int IDX_W = $clog2(NUM_ITEMS),
  localparam int OFF_W = $clog2(MAX_LEN),
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              pre_we,
  input  logic              pre_len_we,
  input  logic              pre_bank,
  input  logic [IDX_W-1:0]  pre_idx,
  input  logic [OFF_W-1:0]  pre_off,
  input  logic [7:0]        pre_byte,
  input  logic [7:0]        pre_len,
  output logic              done,
  output logic              done_bank,
  output logic [IDX_W-1:0]  done_idx
);
  cfgp_key_t        cur_key;
  logic             key_ok;
  logic [LEN_W-1:0] off;
  logic [LEN_W-1:0] len;
  logic [7:0]       byte_at;
  logic [IDX_W-1:0] idx_safe;
  logic             sel_wr, dat_wr, dat_rd, any_rd;
  logic             in_item, rd_hit, wr_take, wr_last;

  assign sel_wr = bus_valid && bus_write && (int'(bus_addr) == SEL_ADDR);
  assign dat_wr = bus_valid && bus_write && (int'(bus_addr) == DATA_ADDR);
  assign any_rd = bus_valid && !bus_write;
  assign dat_rd = any_rd && (int'(bus_addr) == DATA_ADDR);

  cfgp_key_dec #(.NUM_ITEMS(NUM_ITEMS)) u_key (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_wr), .sel_key(bus_wdata),
    .cur_key(cur_key), .key_ok(key_ok)
  );

  // an invalid key never addresses storage; index 0 is used as a safe stand-in
  assign idx_safe = key_ok ? cur_key.idx[IDX_W-1:0] : '0;

  cfgp_store #(
    .NUM_ITEMS(NUM_ITEMS), .MAX_LEN(MAX_LEN), .SIG_WORD(SIG_WORD), .ID_WORD(ID_WORD)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .pre_we(pre_we), .pre_len_we(pre_len_we), .pre_bank(pre_bank),
    .pre_idx(pre_idx), .pre_off(pre_off), .pre_byte(pre_byte), .pre_len(pre_len),
    .wr_en(wr_take), .wr_byte(bus_wdata[7:0]),
    .cur_bank(cur_key.bank), .cur_idx(idx_safe), .cur_off(off[OFF_W-1:0]),
    .cur_byte(byte_at), .cur_len(len)
  );

  assign in_item = key_ok && (off < len);
  assign rd_hit  = dat_rd && in_item;
  assign wr_take = dat_wr && in_item && cur_key.wr_flag;
  assign wr_last = wr_take && ((off + LEN_W'(1)) == len);

  cfgp_cursor #(.MAX_LEN(MAX_LEN)) u_cur (
    .clk(clk), .rst_n(rst_n),
    .rewind(sel_wr || wr_last),
    .step(rd_hit || wr_take),
    .off(off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
      done_bank <= 1'b0;
      done_idx  <= '0;
    end else begin
      rd_valid <= any_rd;
      rd_data  <= rd_hit ? byte_at : 8'h00;
      done     <= wr_last;
      if (wr_last) begin
        done_bank <= cur_key.bank;
        done_idx  <= idx_safe;
      end
    end
  end
endmodule

// File: rtl/cfgp_port_chk.sv
`timescale 1ns/1ps
module cfgp_port_chk #(
  parameter int NUM_ITEMS = 16,
  parameter int ADDR_W    = 2,
  parameter int SEL_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic              done
);
  logic is_sel, is_dwr, is_drd, is_orRd;
  assign is_sel  = bus_valid && bus_write && (int'(bus_addr) == SEL_ADDR);
  assign is_dwr  = bus_valid && bus_write && (int'(bus_addr) == DATA_ADDR);
  assign is_drd  = bus_valid && !bus_write && (int'(bus_addr) == DATA_ADDR);
  assign is_orRd = bus_valid && !bus_write && (int'(bus_addr) != DATA_ADDR);

  // R4
  rd_resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && !bus_write));

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_valid && bus_write && (int'(bus_addr) == DATA_ADDR)));

  // R3
  bad_key_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sel && int'(bus_wdata[13:0]) >= NUM_ITEMS) ##1 is_drd |=> (rd_data == 8'h00));

  // R6
  no_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sel && !bus_wdata[14]) ##1 is_dwr |=> !done);

  // R8
  other_addr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_orRd |=> (rd_valid && rd_data == 8'h00));
endmodule

bind cfgp_port cfgp_port_chk #(
  .NUM_ITEMS(NUM_ITEMS), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .done(done)
);

// File: tb/cfgp_port_test.sv
`timescale 1ns/1ps
module cfgp_port_test;
  localparam int NI = 12;
  localparam int ML = 8;
  localparam int SA = 0;
  localparam int DA = 2;
  localparam int IW = $clog2(NI);
  localparam int OW = $clog2(ML);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic pre_we = 1'b0, pre_len_we = 1'b0, pre_bank = 1'b0;
  logic [IW-1:0] pre_idx = '0;
  logic [OW-1:0] pre_off = '0;
  logic [7:0] pre_byte = '0, pre_len = '0;
  logic done, done_bank;
  logic [IW-1:0] done_idx;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0]  m_mem [2][16][ML];
  int          m_len [2][16];
  logic [15:0] m_key;
  bit          m_ok;
  int          m_off;
  logic [7:0]  last_rd;

  always #4 clk = ~clk;

  cfgp_port #(.NUM_ITEMS(NI), .MAX_LEN(ML), .ADDR_W(2), .SEL_ADDR(SA), .DATA_ADDR(DA)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .pre_we(pre_we), .pre_len_we(pre_len_we), .pre_bank(pre_bank), .pre_idx(pre_idx),
    .pre_off(pre_off), .pre_byte(pre_byte), .pre_len(pre_len),
    .done(done), .done_bank(done_bank), .done_idx(done_idx)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin
        m_len[b][i] = 0;
        for (int o = 0; o < ML; o++) m_mem[b][i][o] = 8'h00;
      end
    m_mem[0][0][0] = 8'h43; m_mem[0][0][1] = 8'h46;
    m_mem[0][0][2] = 8'h47; m_mem[0][0][3] = 8'h50;
    m_mem[0][1][0] = 8'h01;
    m_len[0][0] = 4; m_len[0][1] = 4;
    m_key = 16'h0000; m_ok = 1'b1; m_off = 0;
  endfunction

  function automatic int cur_b(); return int'(m_key[15]); endfunction
  function automatic int cur_i(); return int'(m_key[3:0]); endfunction

  function automatic logic [7:0] model_read(int a);
    logic [7:0] r = 8'h00;
    if (a == DA && m_ok && m_off < m_len[cur_b()][cur_i()]) begin
      r = m_mem[cur_b()][cur_i()][m_off];
      m_off++;
    end
    return r;
  endfunction

  // returns 1 when the write completes an item
  function automatic bit model_write(int a, logic [7:0] v);
    if (a == DA && m_ok && m_key[14] && m_off < m_len[cur_b()][cur_i()]) begin
      m_mem[cur_b()][cur_i()][m_off] = v;
      m_off++;
      if (m_off == m_len[cur_b()][cur_i()]) begin
        m_off = 0;
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic op(bit w, int a, logic [15:0] d, string tag);
    logic [7:0] exp_rd = 8'h00;
    bit exp_done = 1'b0;
    int eb = cur_b();
    int ei = cur_i();
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = 2'(a); bus_wdata = d;
    if (w && a == SA) begin
      m_off = 0;
      if (int'(d[13:0]) >= NI) begin m_key = 16'hFFFF; m_ok = 1'b0; end
      else begin m_key = d; m_ok = 1'b1; end
    end else if (w) begin
      exp_done = model_write(a, d[7:0]);
    end else begin
      exp_rd = model_read(a);
    end
    @(posedge clk);
    #2;
    bus_valid = 1'b0;
    if (!w) begin
      check(rd_valid == 1'b1, tag, int'(rd_valid), 1);
      check(rd_data == exp_rd, tag, int'(rd_data), int'(exp_rd));
      last_rd = rd_data;
    end else begin
      check(rd_valid == 1'b0, tag, int'(rd_valid), 0);
    end
    check(done == exp_done, exp_done ? "R7" : tag, int'(done), int'(exp_done));
    if (exp_done) begin
      check(done_bank == eb[0], "R7", int'(done_bank), eb);
      check(int'(done_idx) == ei, "R7", int'(done_idx), ei);
    end
  endtask

  task automatic pload_byte(int b, int i, int o, logic [7:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_bank = b[0]; pre_idx = IW'(i); pre_off = OW'(o); pre_byte = v;
    m_mem[b][i][o] = v;
    @(posedge clk);
    #2;
    pre_we = 1'b0;
  endtask

  task automatic pload_len(int b, int i, int l);
    @(negedge clk);
    pre_len_we = 1'b1; pre_bank = b[0]; pre_idx = IW'(i); pre_len = 8'(l);
    m_len[b][i] = (l > ML) ? ML : l;
    @(posedge clk);
    #2;
    pre_len_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd90210));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    check(done == 1'b0, "R1", int'(done), 0);
    op(1'b0, DA, 16'h0, "R1");
    check(last_rd == 8'h43, "R1", int'(last_rd), 8'h43);
    for (int k = 0; k < 3; k++) op(1'b0, DA, 16'h0, "R1");
    check(last_rd == 8'h50, "R1", int'(last_rd), 8'h50);
    // R5 read past end, then lengthen the item: the offset did not move
    op(1'b0, DA, 16'h0, "R5");
    op(1'b0, DA, 16'h0, "R5");
    pload_len(0, 0, 6);
    pload_byte(0, 0, 4, 8'hAA);
    op(1'b0, DA, 16'h0, "R5");
    check(last_rd == 8'hAA, "R5", int'(last_rd), 8'hAA);
    // R2 identifier item and rewind on re-select
    op(1'b1, SA, 16'h0001, "R2");
    op(1'b0, DA, 16'h0, "R2");
    check(last_rd == 8'h01, "R1", int'(last_rd), 8'h01);
    op(1'b1, SA, 16'h0001, "R2");
    op(1'b0, DA, 16'h0, "R2");
    check(last_rd == 8'h01, "R2", int'(last_rd), 8'h01);
    // R3 invalid index
    op(1'b1, SA, 16'h400C, "R3");
    op(1'b0, DA, 16'h0, "R3");
    op(1'b1, DA, 16'h0055, "R3");
    op(1'b1, SA, 16'h0000, "R3");
    op(1'b0, DA, 16'h0, "R3");
    check(last_rd == 8'h43, "R3", int'(last_rd), 8'h43);
    // R6 write gating and R7 completion
    pload_len(0, 5, 3);
    for (int k = 0; k < 3; k++) pload_byte(0, 5, k, 8'(k + 1));
    op(1'b1, SA, 16'h0005, "R6");
    op(1'b1, DA, 16'h0099, "R6");
    op(1'b0, DA, 16'h0, "R6");
    check(last_rd == 8'h01, "R6", int'(last_rd), 8'h01);
    op(1'b1, SA, 16'h4005, "R6");
    op(1'b1, DA, 16'h0007, "R6");
    op(1'b1, DA, 16'h0008, "R6");
    op(1'b1, DA, 16'h0009, "R7");
    op(1'b1, DA, 16'h000A, "R7");
    op(1'b1, SA, 16'h0005, "R7");
    op(1'b0, DA, 16'h0, "R7");
    check(last_rd == 8'h0A, "R7", int'(last_rd), 8'h0A);
    op(1'b0, DA, 16'h0, "R6");
    check(last_rd == 8'h08, "R6", int'(last_rd), 8'h08);
    // R10 bank separation
    pload_len(1, 5, 2);
    op(1'b1, SA, 16'hC005, "R10");
    op(1'b1, DA, 16'h0033, "R10");
    op(1'b1, DA, 16'h0044, "R10");
    op(1'b1, SA, 16'h0005, "R10");
    op(1'b0, DA, 16'h0, "R10");
    check(last_rd == 8'h0A, "R10", int'(last_rd), 8'h0A);
    op(1'b1, SA, 16'h8005, "R10");
    op(1'b0, DA, 16'h0, "R10");
    check(last_rd == 8'h33, "R10", int'(last_rd), 8'h33);
    // R8 other addresses
    op(1'b1, 3, 16'h0000, "R8");
    op(1'b0, 1, 16'h0, "R8");
    op(1'b0, SA, 16'h0, "R8");
    op(1'b0, DA, 16'h0, "R8");
    check(last_rd == 8'h44, "R8", int'(last_rd), 8'h44);
    // R9 length clamp
    pload_len(1, 2, 200);
    for (int k = 0; k < ML; k++) pload_byte(1, 2, k, 8'(8'h10 + k));
    op(1'b1, SA, 16'h8002, "R9");
    for (int k = 0; k < ML; k++) op(1'b0, DA, 16'h0, "R9");
    check(last_rd == 8'(8'h10 + ML - 1), "R9", int'(last_rd), 8'h10 + ML - 1);
    op(1'b0, DA, 16'h0, "R9");
    check(last_rd == 8'h00, "R9", int'(last_rd), 0);
    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 10);
      int a = ($urandom % 8 == 0) ? int'($urandom % 4) : DA;
      if (r < 2) begin
        logic [15:0] k = {$urandom % 2 == 0, $urandom % 3 != 0, 14'($urandom % 15)};
        op(1'b1, SA, k, "R2");
      end else if (r < 5) op(1'b0, a, 16'h0, "R4");
      else if (r < 8) op(1'b1, a, 16'($urandom % 256), "R6");
      else if (r < 9) pload_byte(int'($urandom % 2), int'($urandom % NI), int'($urandom % ML), 8'($urandom));
      else pload_len(int'($urandom % 2), int'($urandom % NI), int'($urandom % (ML + 3)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule